// File: doc/BRIEF.md
# Round-Robin Shared-Bus Arbiter with Atomic Locking

This block decides which of several bus agents may drive a shared memory bus. A request is presented per agent, and a single grant is issued one cycle after arbitration. Grants rotate round-robin, so each agent waits at most for every other agent to finish one tenure. The granted agent keeps the bus until the bus side reports that its transfer has completed.

An agent can flag its request as atomic. It does this either with an explicit lock flag or by marking it as an exchange, and an exchange is always atomic. When an atomic request is granted, the arbiter raises a bus-lock output. It then refuses every other agent until the owner lets go, and the owner may run back-to-back transfers, for example the read and write halves of a read-modify-write. When the requester also reports that the target is cached write-back and the whole access fits inside one 64-byte line, the atomic operation is signalled as a cache lock and the bus lock stays low. An access that straddles a line boundary falls back to a bus lock.

Because only one grant exists at any time and a lock tenure cannot be interrupted, all atomic sequences from all agents complete in one global order, and no two of them overlap.

Top module: `shared_bus_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is set at a time, and when one is set, `gnt_id_o` holds its index.
- R2: From idle, the next rising edge grants the first requesting agent found by searching upward and circularly from the rotation pointer. After reset the pointer is agent 0.
- R3: A grant is held unchanged until `done_i` is sampled high. A tenure that is not a continuing lock then ends: `gnt_o` is zero on the following cycle, and a new grant can appear one cycle later.
- R4: When a tenure ends, the rotation pointer moves to the agent just above the one that held the grant, wrapping from the highest agent to agent 0.
- R5: A granted request with `lock_i` set and no cache lock raises `bus_lock_o` in the same cycle that the grant appears.
- R6: A request with `xchg_i` set is atomic even when `lock_i` is low, both when it is first granted and when the lock is continued.
- R7: While `bus_lock_o` is high, no other agent receives a grant. If the owner's `lock_i` or `xchg_i` is high when `done_i` is sampled, it keeps both the grant and the bus lock, and the rotation pointer does not move.
- R8: If the owner's `lock_i` and `xchg_i` are both low when `done_i` is sampled during a bus lock, then `bus_lock_o` and the grant are low on the next cycle.
- R9: An atomic request with `wb_i` set is a cache lock when its first byte `addr` and last byte `addr + size` share bits [31:6] with no carry out of bit 31. In that case `cache_lock_o` is high with the grant and `bus_lock_o` stays low. `size_i` holds the byte count minus one.
- R10: An atomic request whose access crosses a 64-byte boundary, or that wraps past the top of the address space, takes a bus lock even with `wb_i` set. An atomic request with `wb_i` low also takes a bus lock.
- R11: A request with neither `lock_i` nor `xchg_i` raises neither lock output.
- R12: During reset and right after it, `gnt_o`, `bus_lock_o` and `cache_lock_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Bus request, one bit per agent |
| lock_i | input | 4 | Atomic flag per agent; held high to keep a lock |
| xchg_i | input | 4 | Exchange-type request per agent, always atomic |
| wb_i | input | 4 | Target is cached write-back |
| addr_i | input | 128 | First byte address per agent, agent k in bits [32k+31:32k] |
| size_i | input | 24 | Byte count minus one per agent, agent k in bits [6k+5:6k] |
| done_i | input | 1 | Current transfer of the granted agent completes this cycle |
| gnt_o | output | 4 | One-hot grant |
| gnt_id_o | output | 2 | Index of the granted agent |
| bus_lock_o | output | 1 | Bus lock held; all other agents are blocked |
| cache_lock_o | output | 1 | Atomic operation handled as a cache lock |

## Verification
The assertions assume that `done_i` arrives only while a grant is live. They also assume that an agent's request and its atomic flags stay steady until its grant appears. The bench drives every input on the falling clock edge. It raises `done_i` for a single cycle and only after it has seen the grant, and it lowers a lock owner's flags in the same cycle as its last `done_i` pulse. A competing agent is raised only while another agent owns the bus, so the freeze under lock can be observed.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_BUS   = 2'd1,
    LK_CACHE = 2'd2
  } lock_kind_e;

  // Atomic traffic takes a cache lock only when the line check agrees.
  function automatic lock_kind_e classify(input logic atomic, input logic contained);
    if (!atomic)        return LK_NONE;
    else if (contained) return LK_CACHE;
    else                return LK_BUS;
  endfunction
endpackage

// File: rtl/sba_line_check.sv
module sba_line_check #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 6,
  parameter int OFFS_W = 6
) (
  input  logic              wb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size_m1,
  output logic              contained
);
  localparam int EXT_W = ADDR_W + 1;

  // First and last byte must share a line; a carry out of the top counts as crossing.
  function automatic logic same_line(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] s);
    logic [EXT_W-1:0] last;
    last = {1'b0, a} + EXT_W'(s);
    return last[EXT_W-1:OFFS_W] == {1'b0, a[ADDR_W-1:OFFS_W]};
  endfunction

  assign contained = wb & same_line(addr, size_m1);
endmodule

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [N-1:0]   req,
  input  logic [IDW-1:0] ptr,
  output logic           valid,
  output logic [IDW-1:0] idx
);
  // Walk from the highest offset down so the nearest requester wins last.
  function automatic logic [IDW-1:0] first_from(input logic [N-1:0] r, input logic [IDW-1:0] p);
    logic [IDW-1:0] sel;
    int j;
    sel = p;
    for (int k = N - 1; k >= 0; k--) begin
      j = int'(p) + k;
      if (j >= N) j = j - N;
      if (r[j]) sel = IDW'(j);
    end
    return sel;
  endfunction

  assign valid = |req;
  assign idx   = first_from(req, ptr);
endmodule

// File: rtl/sba_owner_fsm.sv
module sba_owner_fsm
  import sba_pkg::*;
#(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pick_valid,
  input  logic [IDW-1:0] pick_idx,
  input  lock_kind_e     pick_kind,
  input  logic           done,
  input  logic           hold_req,
  output logic           busy,
  output logic [IDW-1:0] owner,
  output logic           bus_lk,
  output logic           cache_lk,
  output logic [IDW-1:0] ptr,
  output logic           grant_start,
  output logic           grant_end,
  output logic           seq_continue
);
  function automatic logic [IDW-1:0] after(input logic [IDW-1:0] o);
    if (int'(o) == N - 1) return '0;
    else                  return o + 1'b1;
  endfunction

  assign grant_start  = !busy && pick_valid;
  assign seq_continue = busy && done && bus_lk && hold_req;
  assign grant_end    = busy && done && !seq_continue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      owner    <= '0;
      bus_lk   <= 1'b0;
      cache_lk <= 1'b0;
      ptr      <= '0;
    end else if (grant_start) begin
      busy     <= 1'b1;
      owner    <= pick_idx;
      bus_lk   <= (pick_kind == LK_BUS);
      cache_lk <= (pick_kind == LK_CACHE);
    end else if (grant_end) begin
      busy     <= 1'b0;
      bus_lk   <= 1'b0;
      cache_lk <= 1'b0;
      ptr      <= after(owner);
    end
  end
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
  import sba_pkg::*;
#(
  parameter int N_AGENTS   = 4,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 6,
  parameter int LINE_BYTES = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_AGENTS-1:0]          req_i,
  input  logic [N_AGENTS-1:0]          lock_i,
  input  logic [N_AGENTS-1:0]          xchg_i,
  input  logic [N_AGENTS-1:0]          wb_i,
  input  logic [N_AGENTS*ADDR_W-1:0]   addr_i,
  input  logic [N_AGENTS*SIZE_W-1:0]   size_i,
  input  logic                         done_i,
  output logic [N_AGENTS-1:0]          gnt_o,
  output logic [$clog2(N_AGENTS)-1:0]  gnt_id_o,
  output logic                         bus_lock_o,
  output logic                         cache_lock_o
);
  localparam int IDW    = $clog2(N_AGENTS);
  localparam int OFFS_W = $clog2(LINE_BYTES);

  lock_kind_e        kind_a [N_AGENTS];
  logic [N_AGENTS-1:0] contained;
  logic              pick_valid;
  logic [IDW-1:0]    pick_idx;
  logic [IDW-1:0]    ptr;
  logic [IDW-1:0]    owner;
  logic              busy, bus_lk, cache_lk;
  logic              grant_start, grant_end, seq_continue;
  logic              hold_req;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    sba_line_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFFS_W(OFFS_W)) u_line (
      .wb        (wb_i[g]),
      .addr      (addr_i[g*ADDR_W +: ADDR_W]),
      .size_m1   (size_i[g*SIZE_W +: SIZE_W]),
      .contained (contained[g])
    );
    assign kind_a[g] = classify(lock_i[g] | xchg_i[g], contained[g]);
  end

  sba_rr_pick #(.N(N_AGENTS), .IDW(IDW)) u_pick (
    .req   (req_i),
    .ptr   (ptr),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  assign hold_req = lock_i[owner] | xchg_i[owner];

  sba_owner_fsm #(.N(N_AGENTS), .IDW(IDW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pick_valid   (pick_valid),
    .pick_idx     (pick_idx),
    .pick_kind    (kind_a[pick_idx]),
    .done         (done_i),
    .hold_req     (hold_req),
    .busy         (busy),
    .owner        (owner),
    .bus_lk       (bus_lk),
    .cache_lk     (cache_lk),
    .ptr          (ptr),
    .grant_start  (grant_start),
    .grant_end    (grant_end),
    .seq_continue (seq_continue)
  );

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_gnt
    assign gnt_o[g] = busy && (owner == IDW'(g));
  end

  assign gnt_id_o     = owner;
  assign bus_lock_o   = bus_lk;
  assign cache_lock_o = cache_lk;
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   req,
  input logic [N-1:0]   lock_in,
  input logic [N-1:0]   xchg_in,
  input logic           done,
  input logic [N-1:0]   gnt,
  input logic [IDW-1:0] gnt_id,
  input logic           bus_lock,
  input logic           cache_lock,
  input logic           grant_start,
  input logic           seq_continue
);
  logic owner_holds;
  assign owner_holds = |(gnt & (lock_in | xchg_in));

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R1
  AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (|gnt) |-> gnt[gnt_id]); // R1
  AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n) grant_start |=> |(gnt & $past(req))); // R2
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((|gnt) && !done) |=> $stable(gnt)); // R3
  AST_LOCK_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n) (bus_lock || cache_lock) |-> (|gnt)); // R5
  AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(bus_lock && cache_lock)); // R9
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) bus_lock |=> ((gnt == $past(gnt)) || (gnt == '0))); // R7
  AST_LOCK_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n) seq_continue |=> (bus_lock && $stable(gnt))); // R7
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) ((|gnt) && done && !(bus_lock && owner_holds)) |=> ((gnt == '0) && !bus_lock && !cache_lock)); // R8
endmodule

bind shared_bus_arbiter sba_checker #(.N(N_AGENTS), .IDW($clog2(N_AGENTS))) u_sba_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req          (req_i),
  .lock_in      (lock_i),
  .xchg_in      (xchg_i),
  .done         (done_i),
  .gnt          (gnt_o),
  .gnt_id       (gnt_id_o),
  .bus_lock     (bus_lock_o),
  .cache_lock   (cache_lock_o),
  .grant_start  (grant_start),
  .seq_continue (seq_continue)
);

// File: tb/test_shared_bus_arbiter.sv
`timescale 1ns/1ps
module test_shared_bus_arbiter;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int SW = 6;

  typedef struct packed {
    logic [1:0]    agent;
    logic          lk;
    logic          xc;
    logic          wb;
    logic [AW-1:0] addr;
    logic [SW-1:0] size;
    logic          exp_bus;
    logic          exp_cache;
  } vec_t;

  // agent, lock, xchg, wb, addr, size-1, expected bus lock, expected cache lock
  localparam vec_t VEC [10] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0100, 6'd3,  1'b0, 1'b0}, // R11 plain
    '{2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_0100, 6'd3,  1'b1, 1'b0}, // R10 not write-back
    '{2'd2, 1'b0, 1'b1, 1'b1, 32'h0000_0140, 6'd7,  1'b0, 1'b1}, // R6 R9 exchange in line
    '{2'd3, 1'b1, 1'b0, 1'b1, 32'h0000_013C, 6'd7,  1'b1, 1'b0}, // R10 crosses 0x140
    '{2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_01C0, 6'd63, 1'b0, 1'b1}, // R9 whole line
    '{2'd1, 1'b1, 1'b0, 1'b1, 32'h0000_01C1, 6'd63, 1'b1, 1'b0}, // R10 one byte over
    '{2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 6'd0,  1'b1, 1'b0}, // R6 exchange bus lock
    '{2'd3, 1'b0, 1'b0, 1'b1, 32'h0000_0040, 6'd0,  1'b0, 1'b0}, // R11 plain write-back
    '{2'd0, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFC0, 6'd63, 1'b0, 1'b1}, // R9 top line
    '{2'd1, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFC1, 6'd63, 1'b1, 1'b0}  // R10 wraps address space
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_i = '0, lock_i = '0, xchg_i = '0, wb_i = '0;
  logic [N*AW-1:0] addr_i = '0;
  logic [N*SW-1:0] size_i = '0;
  logic            done_i = 1'b0;
  logic [N-1:0]    gnt_o;
  logic [1:0]      gnt_id_o;
  logic            bus_lock_o, cache_lock_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  shared_bus_arbiter i_shared_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .lock_i(lock_i), .xchg_i(xchg_i),
    .wb_i(wb_i), .addr_i(addr_i), .size_i(size_i), .done_i(done_i),
    .gnt_o(gnt_o), .gnt_id_o(gnt_id_o), .bus_lock_o(bus_lock_o), .cache_lock_o(cache_lock_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_i = '0; lock_i = '0; xchg_i = '0; wb_i = '0; done_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R12: reset state
    @(negedge clk);
    chk("R12 gnt in reset", 32'(gnt_o), 32'h0);
    chk("R12 bus_lock in reset", 32'(bus_lock_o), 32'h0);
    chk("R12 cache_lock in reset", 32'(cache_lock_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 gnt after reset", 32'(gnt_o), 32'h0);

    // Table walk: one requester per vector
    for (int v = 0; v < 10; v++) begin
      int a;
      a = int'(VEC[v].agent);
      req_i = '0; lock_i = '0; xchg_i = '0; wb_i = '0;
      req_i[a] = 1'b1; lock_i[a] = VEC[v].lk; xchg_i[a] = VEC[v].xc; wb_i[a] = VEC[v].wb;
      addr_i[a*AW +: AW] = VEC[v].addr;
      size_i[a*SW +: SW] = VEC[v].size;
      @(negedge clk);
      chk($sformatf("R2 vec%0d gnt", v), 32'(gnt_o), 32'(1) << a);
      chk($sformatf("R1 vec%0d gnt_id", v), 32'(gnt_id_o), 32'(a));
      chk($sformatf("R5 R10 vec%0d bus_lock", v), 32'(bus_lock_o), 32'(VEC[v].exp_bus));
      chk($sformatf("R9 R11 vec%0d cache_lock", v), 32'(cache_lock_o), 32'(VEC[v].exp_cache));
      done_i = 1'b1; req_i = '0; lock_i = '0; xchg_i = '0;
      @(negedge clk);
      done_i = 1'b0;
      chk($sformatf("R8 vec%0d gnt released", v), 32'(gnt_o), 32'h0);
      chk($sformatf("R8 vec%0d locks dropped", v), 32'({bus_lock_o, cache_lock_o}), 32'h0);
    end

    // R2 R3 R4: rotation with all agents requesting
    do_reset();
    req_i = '1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk($sformatf("R4 rotation step %0d", k), 32'(gnt_o), 32'(1) << (k % N));
      repeat (2) @(negedge clk);
      chk($sformatf("R3 hold step %0d", k), 32'(gnt_o), 32'(1) << (k % N));
      done_i = 1'b1;
      @(negedge clk);
      done_i = 1'b0;
      chk($sformatf("R3 gap step %0d", k), 32'(gnt_o), 32'h0);
    end

    // R5 R6 R7 R8: lock held across transfers, others blocked
    do_reset();
    req_i = 4'b0100; lock_i = 4'b0100; wb_i = '0;
    @(negedge clk);
    chk("R5 lock granted", 32'(gnt_o), 32'h4);
    chk("R5 bus_lock up", 32'(bus_lock_o), 32'h1);
    req_i = 4'b1111;
    @(negedge clk);
    chk("R7 others blocked", 32'(gnt_o), 32'h4);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    chk("R7 owner keeps grant", 32'(gnt_o), 32'h4);
    chk("R7 bus_lock kept", 32'(bus_lock_o), 32'h1);
    done_i = 1'b1; lock_i = 4'b0000; xchg_i = 4'b0100;
    @(negedge clk);
    done_i = 1'b0;
    chk("R6 exchange continues lock", 32'(gnt_o), 32'h4);
    chk("R6 bus_lock kept by exchange", 32'(bus_lock_o), 32'h1);
    done_i = 1'b1; xchg_i = '0; req_i = 4'b1011;
    @(negedge clk);
    done_i = 1'b0;
    chk("R8 grant dropped", 32'(gnt_o), 32'h0);
    chk("R8 bus_lock dropped", 32'(bus_lock_o), 32'h0);
    @(negedge clk);
    chk("R4 pointer past lock owner", 32'(gnt_o), 32'h8);
    chk("R11 plain after lock", 32'(bus_lock_o), 32'h0);
    done_i = 1'b1; req_i = '0;
    @(negedge clk);
    done_i = 1'b0;
    chk("R3 final release", 32'(gnt_o), 32'h0);

    summary();
    $finish;
  end
endmodule